// File: doc/BRIEF.md
# Selective-Wake Status Flag Keeper

This block holds the four status flags that a CAN selective-wake receiver reports to its host controller. It also produces a one-cycle interrupt pulse on bus-silence timeouts and a one-cycle wake request out of sleep.

The block takes single-cycle event pulses from the surrounding logic:

- a silence-timer expiry
- a valid-frame report
- a protocol-error report
- a wake pattern
- an error-counter overflow
- a frame wake
- a selective-wake enable event
- a system-error event

It also samples the current wake-detection state, the power mode, the receiver operating mode, the selective-wake request bit, a timeout-clear strobe and a timeout interrupt mask. The silence timer and the frame decoder sit outside.

A single silence timeout sets two flags, and each flag is cleared by a different agent. The host clears the timeout flag. A wake pattern on the bus clears the silence flag. An interrupt fires on every qualifying timeout, even when the timeout flag is still set from an earlier one. A timeout never wakes the device.

Top module: `pnStatusFlags`

## Requirements
Encodings used below:
- `detState`: 0 frame-detect, 1 pattern-detect 1, 2 pattern-detect 2, 3 other.
- `powerMode`: 0 normal, 1 stop, 2 sleep, 3 restart.
- `rxMode`: 0 off, 1 normal, 2 receive-only, 3 frame-detect.

All flag and pulse outputs are registered. They show the effect of the inputs seen at a rising edge in the cycle that follows that edge.

- R1: `timeoutFlag` becomes 1 after a `silenceExpire` pulse while `detState` is 0 or 2. An expiry in state 1 or 3 leaves it unchanged.
- R2: `clrTimeout` clears `timeoutFlag`. A qualifying expiry in the same cycle wins, and the flag stays 1.
- R3: `irqPulse` is high for exactly the one cycle after each qualifying expiry (as in R1) when `timeoutMask` is 1 and `powerMode` is 0 or 1. This holds whether or not `timeoutFlag` was already 1.
- R4: `irqPulse` stays 0 when `timeoutMask` is 0 or `powerMode` is 2 or 3.
- R5: `wakeReq` pulses for one cycle only while `powerMode` is 2, and only after one of these events: `errCntOvf`, `wakePattern` in state 2, or `frameWake` in state 0. A silence expiry never raises it.
- R6: `silenceFlag` is set by a qualifying expiry (as in R1). A `wakePattern` in any state clears it, and a set in the same cycle wins.
- R7: While `rxMode` is 1, 2 or 3, `frameValid` sets `syncFlag` and `protoError` clears it, with the set winning. With `rxMode` 0, `syncFlag` holds.
- R8: `swkSetFlag` is set by `swkEnable` in state 0 or 1, and by `sysError` in state 2.
- R9: `swkSetFlag` is cleared by any of:
  - `errCntOvf`
  - `wakePattern` in state 2
  - `frameWake` in state 0

  A set from R8 in the same cycle wins.
- R10: While `swkRequest` is 0, `swkSetFlag` is 0 in the next cycle, whatever set event occurs.
- R11: After reset all flags, `irqPulse` and `wakeReq` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| detState | input | 2 | Wake-detection state |
| powerMode | input | 2 | Device power mode |
| rxMode | input | 2 | Receiver operating mode |
| silenceExpire | input | 1 | Silence-timer expiry pulse |
| frameValid | input | 1 | Valid frame received pulse |
| protoError | input | 1 | CAN protocol error pulse |
| wakePattern | input | 1 | Wake-up pattern pulse |
| errCntOvf | input | 1 | Error-counter overflow pulse |
| frameWake | input | 1 | Wake-frame match pulse |
| swkEnable | input | 1 | Selective wake enabled event |
| sysError | input | 1 | System-error event |
| swkRequest | input | 1 | Selective-wake request bit |
| clrTimeout | input | 1 | Host clear strobe for the timeout flag |
| timeoutMask | input | 1 | Timeout interrupt enable |
| timeoutFlag | output | 1 | Bus timeout flag |
| silenceFlag | output | 1 | Bus silence flag |
| syncFlag | output | 1 | Receiver synchronised flag |
| swkSetFlag | output | 1 | Selective wake armed flag |
| irqPulse | output | 1 | One-cycle timeout interrupt |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
Three kinds of same-cycle conflict get direct attention:
- A silence expiry with the host's timeout clear.
- A silence expiry with a wake pattern, which sets the silence flag while trying to clear it.
- A selective-wake arming event with a wake event or a dropped request bit.

The bench reaches every one of these conflicts by sweeping all combinations of detection state, power mode, mask and event pulses in single cycles. It predicts each flag from a running model of the requirement rules and compares the flags in the following cycle. It also holds the timeout flag set across repeated expiries, to show that the interrupt still fires each time.

// File: rtl/pn_status_pkg.sv
package pn_status_pkg;

  localparam int DET_W  = 2;
  localparam int MODE_W = 2;
  localparam int NUM_FLAGS = 4;

  localparam int FL_TIMEOUT = 0;
  localparam int FL_SILENCE = 1;
  localparam int FL_SYNC    = 2;
  localparam int FL_SWK     = 3;

  typedef enum logic [DET_W-1:0] {
    DET_FRAME = 2'd0,
    DET_PAT1  = 2'd1,
    DET_PAT2  = 2'd2,
    DET_OTHER = 2'd3
  } detState_e;

  typedef enum logic [MODE_W-1:0] {
    PM_NORMAL  = 2'd0,
    PM_STOP    = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_RESTART = 2'd3
  } powerMode_e;

  typedef enum logic [MODE_W-1:0] {
    RX_OFF    = 2'd0,
    RX_NORMAL = 2'd1,
    RX_RXONLY = 2'd2,
    RX_FRAME  = 2'd3
  } rxMode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_FLAGS-1:0] setVec;
    logic [NUM_FLAGS-1:0] clrVec;
    logic [NUM_FLAGS-1:0] killVec;
    logic                 irqFire;
    logic                 wakeFire;
  } pnStrobes_t;

endpackage

// File: rtl/pnStatusCtrl.sv
module pnStatusCtrl
  import pn_status_pkg::*;
(
  input  logic [DET_W-1:0]  detState,
  input  logic [MODE_W-1:0] powerMode,
  input  logic [MODE_W-1:0] rxMode,
  input  logic              silenceExpire,
  input  logic              frameValid,
  input  logic              protoError,
  input  logic              wakePattern,
  input  logic              errCntOvf,
  input  logic              frameWake,
  input  logic              swkEnable,
  input  logic              sysError,
  input  logic              swkRequest,
  input  logic              clrTimeout,
  input  logic              timeoutMask,
  output pnStrobes_t        strobes
);

  detState_e  det;
  powerMode_e pm;
  rxMode_e    rxm;
  logic inFrame, inPat1, inPat2;
  logic timeoutEvt, rxActive, armEvt, wakeEvt, irqModeOk;

  always_comb begin
    det = detState_e'(detState);
    pm  = powerMode_e'(powerMode);
    rxm = rxMode_e'(rxMode);

    inFrame = (det == DET_FRAME);
    inPat1  = (det == DET_PAT1);
    inPat2  = (det == DET_PAT2);

    // Silence expiry only counts in frame-detect or pattern-detect 2.
    timeoutEvt = silenceExpire && (inFrame || inPat2);
    rxActive   = (rxm != RX_OFF);
    armEvt     = (swkEnable && (inFrame || inPat1)) || (sysError && inPat2);
    wakeEvt    = errCntOvf || (wakePattern && inPat2) || (frameWake && inFrame);
    irqModeOk  = (pm == PM_NORMAL) || (pm == PM_STOP);

    strobes = '0;

    strobes.setVec[FL_TIMEOUT] = timeoutEvt;
    strobes.clrVec[FL_TIMEOUT] = clrTimeout;

    strobes.setVec[FL_SILENCE] = timeoutEvt;
    strobes.clrVec[FL_SILENCE] = wakePattern;

    strobes.setVec[FL_SYNC]    = rxActive && frameValid;
    strobes.clrVec[FL_SYNC]    = rxActive && protoError;

    strobes.setVec[FL_SWK]     = armEvt;
    strobes.clrVec[FL_SWK]     = wakeEvt;
    strobes.killVec[FL_SWK]    = !swkRequest;

    strobes.irqFire  = timeoutEvt && timeoutMask && irqModeOk;
    strobes.wakeFire = wakeEvt && (pm == PM_SLEEP);
  end

endmodule

// File: rtl/pnFlagCell.sv
module pnFlagCell (
  input  logic clk,
  input  logic rstN,
  input  logic setIn,
  input  logic clrIn,
  input  logic killIn,
  output logic q
);

  // Priority: kill, then set, then clear, else hold.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       q <= 1'b0;
    else if (killIn) q <= 1'b0;
    else if (setIn)  q <= 1'b1;
    else if (clrIn)  q <= 1'b0;
  end

endmodule

// File: rtl/pnStatusRegs.sv
module pnStatusRegs
  import pn_status_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pnStrobes_t           strobes,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 irqPulse,
  output logic                 wakeReq
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    pnFlagCell uCell (
      .clk    (clk),
      .rstN   (rstN),
      .setIn  (strobes.setVec[i]),
      .clrIn  (strobes.clrVec[i]),
      .killIn (strobes.killVec[i]),
      .q      (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPulse <= 1'b0;
      wakeReq  <= 1'b0;
    end else begin
      irqPulse <= strobes.irqFire;
      wakeReq  <= strobes.wakeFire;
    end
  end

endmodule

// File: rtl/pnStatusFlags.sv
module pnStatusFlags
  import pn_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DET_W-1:0]  detState,
  input  logic [MODE_W-1:0] powerMode,
  input  logic [MODE_W-1:0] rxMode,
  input  logic              silenceExpire,
  input  logic              frameValid,
  input  logic              protoError,
  input  logic              wakePattern,
  input  logic              errCntOvf,
  input  logic              frameWake,
  input  logic              swkEnable,
  input  logic              sysError,
  input  logic              swkRequest,
  input  logic              clrTimeout,
  input  logic              timeoutMask,
  output logic              timeoutFlag,
  output logic              silenceFlag,
  output logic              syncFlag,
  output logic              swkSetFlag,
  output logic              irqPulse,
  output logic              wakeReq
);

  pnStrobes_t           strobes;
  logic [NUM_FLAGS-1:0] flags;

  pnStatusCtrl uCtrl (
    .detState      (detState),
    .powerMode     (powerMode),
    .rxMode        (rxMode),
    .silenceExpire (silenceExpire),
    .frameValid    (frameValid),
    .protoError    (protoError),
    .wakePattern   (wakePattern),
    .errCntOvf     (errCntOvf),
    .frameWake     (frameWake),
    .swkEnable     (swkEnable),
    .sysError      (sysError),
    .swkRequest    (swkRequest),
    .clrTimeout    (clrTimeout),
    .timeoutMask   (timeoutMask),
    .strobes       (strobes)
  );

  pnStatusRegs uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .flags    (flags),
    .irqPulse (irqPulse),
    .wakeReq  (wakeReq)
  );

  assign timeoutFlag = flags[FL_TIMEOUT];
  assign silenceFlag = flags[FL_SILENCE];
  assign syncFlag    = flags[FL_SYNC];
  assign swkSetFlag  = flags[FL_SWK];

endmodule

// File: rtl/pnStatusChk.sv
module pnStatusChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] detState,
  input logic [1:0] powerMode,
  input logic [1:0] rxMode,
  input logic       silenceExpire,
  input logic       frameValid,
  input logic       wakePattern,
  input logic       errCntOvf,
  input logic       frameWake,
  input logic       swkRequest,
  input logic       timeoutMask,
  input logic       timeoutFlag,
  input logic       silenceFlag,
  input logic       syncFlag,
  input logic       swkSetFlag,
  input logic       irqPulse,
  input logic       wakeReq
);

  a_r1_timeout_set: assert property (@(posedge clk) disable iff (!rstN)
    (silenceExpire && (detState == 2'd0 || detState == 2'd2)) |=> timeoutFlag);

  a_r6_silence_set: assert property (@(posedge clk) disable iff (!rstN)
    (silenceExpire && (detState == 2'd0 || detState == 2'd2)) |=> silenceFlag);

  a_r3_irq_fires: assert property (@(posedge clk) disable iff (!rstN)
    (silenceExpire && (detState == 2'd0 || detState == 2'd2) && timeoutMask
     && (powerMode == 2'd0 || powerMode == 2'd1)) |=> irqPulse);

  a_r4_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!timeoutMask || powerMode[1]) |=> !irqPulse);

  a_r5_no_timeout_wake: assert property (@(posedge clk) disable iff (!rstN)
    (!errCntOvf && !wakePattern && !frameWake) |=> !wakeReq);

  a_r7_sync_set: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && rxMode != 2'd0) |=> syncFlag);

  a_r7_sync_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxMode == 2'd0) |=> $stable(syncFlag));

  a_r10_request_kill: assert property (@(posedge clk) disable iff (!rstN)
    !swkRequest |=> !swkSetFlag);

endmodule

bind pnStatusFlags pnStatusChk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .detState      (detState),
  .powerMode     (powerMode),
  .rxMode        (rxMode),
  .silenceExpire (silenceExpire),
  .frameValid    (frameValid),
  .wakePattern   (wakePattern),
  .errCntOvf     (errCntOvf),
  .frameWake     (frameWake),
  .swkRequest    (swkRequest),
  .timeoutMask   (timeoutMask),
  .timeoutFlag   (timeoutFlag),
  .silenceFlag   (silenceFlag),
  .syncFlag      (syncFlag),
  .swkSetFlag    (swkSetFlag),
  .irqPulse      (irqPulse),
  .wakeReq       (wakeReq)
);

// File: tb/sim_pnStatusFlags.sv
module sim_pnStatusFlags;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] detState = 2'd3, powerMode = 2'd0, rxMode = 2'd0;
  logic silenceExpire = 0, frameValid = 0, protoError = 0, wakePattern = 0;
  logic errCntOvf = 0, frameWake = 0, swkEnable = 0, sysError = 0;
  logic swkRequest = 0, clrTimeout = 0, timeoutMask = 0;
  logic timeoutFlag, silenceFlag, syncFlag, swkSetFlag, irqPulse, wakeReq;

  int checks = 0;
  int failures = 0;
  logic mTo = 0, mSil = 0, mSync = 0, mSwk = 0;

  always #10 clk = ~clk;

  pnStatusFlags u0 (
    .clk(clk), .rstN(rstN), .detState(detState), .powerMode(powerMode),
    .rxMode(rxMode), .silenceExpire(silenceExpire), .frameValid(frameValid),
    .protoError(protoError), .wakePattern(wakePattern), .errCntOvf(errCntOvf),
    .frameWake(frameWake), .swkEnable(swkEnable), .sysError(sysError),
    .swkRequest(swkRequest), .clrTimeout(clrTimeout), .timeoutMask(timeoutMask),
    .timeoutFlag(timeoutFlag), .silenceFlag(silenceFlag), .syncFlag(syncFlag),
    .swkSetFlag(swkSetFlag), .irqPulse(irqPulse), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b (det=%0d pm=%0d rx=%0d)",
               req, what, act, exp, detState, powerMode, rxMode);
    end
  endtask

  task automatic quiet();
    silenceExpire = 0; frameValid = 0; protoError = 0; wakePattern = 0;
    errCntOvf = 0; frameWake = 0; swkEnable = 0; sysError = 0; clrTimeout = 0;
  endtask

  // Predict from the requirement rules, clock once, compare.
  task automatic step();
    logic qual, setS, clrS, wakeE, eTo, eSil, eSync, eSwk, eIrq, eWake;
    qual  = silenceExpire && (detState == 2'd0 || detState == 2'd2);
    eTo   = qual ? 1'b1 : (clrTimeout ? 1'b0 : mTo);                   // R1 R2
    eSil  = qual ? 1'b1 : (wakePattern ? 1'b0 : mSil);                 // R6
    eSync = (rxMode == 2'd0) ? mSync :
            (frameValid ? 1'b1 : (protoError ? 1'b0 : mSync));         // R7
    setS  = (swkEnable && detState <= 2'd1) || (sysError && detState == 2'd2);
    wakeE = errCntOvf || (wakePattern && detState == 2'd2) || (frameWake && detState == 2'd0);
    clrS  = wakeE;
    eSwk  = !swkRequest ? 1'b0 : (setS ? 1'b1 : (clrS ? 1'b0 : mSwk)); // R8 R9 R10
    eIrq  = qual && timeoutMask && powerMode <= 2'd1;                  // R3 R4
    eWake = wakeE && powerMode == 2'd2;                                // R5
    @(posedge clk); #1;
    check("R1/R2", "timeoutFlag", timeoutFlag, eTo);
    check("R6", "silenceFlag", silenceFlag, eSil);
    check("R7", "syncFlag", syncFlag, eSync);
    check("R8/R9/R10", "swkSetFlag", swkSetFlag, eSwk);
    check("R3/R4", "irqPulse", irqPulse, eIrq);
    check("R5", "wakeReq", wakeReq, eWake);
    mTo = eTo; mSil = eSil; mSync = eSync; mSwk = eSwk;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check("R11", "timeoutFlag", timeoutFlag, 1'b0);
    check("R11", "silenceFlag", silenceFlag, 1'b0);
    check("R11", "syncFlag", syncFlag, 1'b0);
    check("R11", "swkSetFlag", swkSetFlag, 1'b0);
    check("R11", "irqPulse", irqPulse, 1'b0);
    check("R11", "wakeReq", wakeReq, 1'b0);
    rstN = 1'b1;

    // Timeout / silence / interrupt sweep, including expiry with clear (R2)
    // and expiry with wake pattern (R6).
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p++)
        for (int m = 0; m < 2; m++)
          for (int v = 0; v < 8; v++) begin
            quiet();
            detState = d[1:0]; powerMode = p[1:0]; timeoutMask = m[0];
            silenceExpire = v[0]; clrTimeout = v[1]; wakePattern = v[2];
            step();
          end

    // R3: repeated expiries with the flag never cleared each fire an interrupt.
    quiet();
    detState = 2'd0; powerMode = 2'd1; timeoutMask = 1'b1;
    for (int k = 0; k < 4; k++) begin
      silenceExpire = 1'b1; step();
      silenceExpire = 1'b0; step();
    end

    // R7: sync sweep.
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 4; v++)
        for (int pre = 0; pre < 2; pre++) begin
          quiet(); rxMode = 2'd1; frameValid = pre[0]; protoError = !pre[0]; step();
          quiet(); rxMode = r[1:0]; frameValid = v[0]; protoError = v[1]; step();
        end

    // R8..R10 and R5: arming against wake events across states and modes.
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < 4; p += 2)
        for (int q = 0; q < 2; q++)
          for (int v = 0; v < 32; v++) begin
            quiet(); detState = d[1:0]; powerMode = p[1:0];
            swkRequest = 1'b1; swkEnable = 1'b1; detState = 2'd0; step();
            quiet(); detState = d[1:0]; swkRequest = q[0];
            swkEnable = v[0]; sysError = v[1]; errCntOvf = v[2];
            wakePattern = v[3]; frameWake = v[4];
            step();
          end

    // R5: expiry in sleep alone never wakes.
    quiet(); powerMode = 2'd2; timeoutMask = 1'b1;
    for (int d = 0; d < 4; d++) begin
      detState = d[1:0]; silenceExpire = 1'b1; step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule